// File: doc/BRIEF.md
# Receive Buffer Ring Manager

This block keeps track of where received frames go. Software places a ring of receive buffer descriptors in a small local memory. Each descriptor is four 16-bit words: buffer address low, buffer address high, remaining word count low, and word count high. Four registers bound and track the ring: a start pointer, an end pointer, a read pointer and a write pointer. On a fetch request the block reads the descriptor at the read pointer, one word per cycle. It loads the descriptor into its current-buffer registers and then moves the read pointer on, wrapping back to the start pointer when it reaches the end pointer.

When a frame arrives, the packet side reports its payload length. The block works out how many bytes the frame occupies, including its checksum and alignment padding. It advances the current buffer address by that amount and lowers the remaining word count. A frame that does not fit is refused. When the buffer runs low, the block either fetches the next descriptor on its own or, if software has not yet supplied one, stalls reception until the next fetch. Two sticky flags report an exhausted ring and a refused frame. A mode input selects 16-bit or 32-bit descriptor layout.

Top module: `rxbuf_ring`

## Requirements
- R1: After reset, busy, stalled, exhausted, overrun and last_pkt are 0. cur_addr, cur_wc and rd_ptr are 0. The low-buffer threshold is 0x02F8.
- R2: Register writes use reg_sel 0 = start, 1 = end, 2 = read, 3 = write pointer. In 32-bit mode (wide_mode=1) the written pointer value has bits 1:0 cleared. In 16-bit mode only bit 0 is cleared.
- R3: A fetch keeps busy high for exactly 4 cycles. In those cycles it reads words k=0..3 at byte address rd_ptr + 2k (16-bit mode) or rd_ptr + 4k (32-bit mode). It then sets cur_addr = {word1, word0} and cur_wc = {word3, word2}. reg_sel 6 starts a fetch.
- R4: After a fetch, rd_ptr advances by 8 (16-bit mode) or 16 (32-bit mode). If the result equals the end pointer, rd_ptr becomes the start pointer.
- R5: If rd_ptr equals the write pointer after a fetch, the exhausted flag is set.
- R6: An accepted frame of length L occupies P bytes: L+4 rounded up to a multiple of 2 (16-bit mode) or 4 (32-bit mode). cur_addr grows by P and cur_wc drops by P/2.
- R7: If P exceeds twice cur_wc, the frame is refused. cur_addr and cur_wc stay unchanged, overrun is set and last_pkt is set.
- R8: last_pkt is set on an accepted frame when the new cur_wc is below the threshold (reg_sel 4), and cleared otherwise. Whenever last_pkt is set, a fetch follows at once if rd_ptr differs from the write pointer; if they are equal, stalled is set.
- R9: While stalled, frames are ignored. Any fetch clears stalled.
- R10: Writing reg_sel 5 clears each flag whose bit is 1 in the data (bit 0 exhausted, bit 1 overrun). A 1 in bit 0 while exhausted is set also starts a fetch.
- R11: While busy, register writes and frames are ignored. In a cycle with a register write, a frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1 = 32-bit descriptor layout, 0 = 16-bit |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| mem_addr | output | PTR_W | Byte address into descriptor memory |
| mem_rd | output | 1 | Descriptor memory read enable |
| mem_rdata | input | 16 | Descriptor word, valid in the same cycle |
| pkt_valid | input | 1 | Frame report strobe |
| pkt_len | input | LEN_W | Frame payload length in bytes |
| cur_addr | output | 32 | Current buffer address |
| cur_wc | output | 32 | Remaining word count of current buffer |
| rd_ptr | output | PTR_W | Ring read pointer |
| busy | output | 1 | Fetch in progress |
| stalled | output | 1 | Reception stalled |
| exhausted | output | 1 | Ring exhausted flag |
| overrun | output | 1 | Frame-too-large flag |
| last_pkt | output | 1 | Buffer low after last frame |

## Verification
Fetches are tried in both layouts: at plain positions, at the slot just before the end pointer, and with the read pointer landing on the write pointer. Together these separate correct word order, correct stride, wrap and exhaustion. Frame lengths cover each padding residue, the exact-fit case, one past fit, and the threshold crossing with and without a spare descriptor, which distinguishes refuse, auto-fetch and stall. Random phases mix frames of length 1 to 1600, threshold changes, flag clears and fetch commands in both modes against a bench model of the ring. Writes and frames issued during a fetch show whether they leak into the state.

// File: rtl/rxbuf_ring.sv
module rxbuf_ring #(
  parameter int PTR_W = 16,
  parameter int LEN_W = 16,
  parameter logic [15:0] THR_INIT = 16'h02F8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide_mode,
  input  logic             reg_we,
  input  logic [2:0]       reg_sel,
  input  logic [15:0]      reg_wdata,
  output logic [PTR_W-1:0] mem_addr,
  output logic             mem_rd,
  input  logic [15:0]      mem_rdata,
  input  logic             pkt_valid,
  input  logic [LEN_W-1:0] pkt_len,
  output logic [31:0]      cur_addr,
  output logic [31:0]      cur_wc,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             busy,
  output logic             stalled,
  output logic             exhausted,
  output logic             overrun,
  output logic             last_pkt
);
  localparam int PL_W = LEN_W + 2;

  logic [PTR_W-1:0] start_p, end_p, wr_p;
  logic [15:0]      thr;
  logic [1:0]       cnt;
  logic [15:0]      w0, w1, w2;

  logic [PTR_W-1:0] wmask, desc_sz, next_rd, wrapped;
  assign wmask   = wide_mode ? {{(PTR_W-2){1'b1}}, 2'b00} : {{(PTR_W-1){1'b1}}, 1'b0};
  assign desc_sz = wide_mode ? PTR_W'(16) : PTR_W'(8);
  assign next_rd = rd_ptr + desc_sz;
  assign wrapped = (next_rd == end_p) ? start_p : next_rd;

  assign mem_rd   = busy;
  assign mem_addr = rd_ptr + (PTR_W'(cnt) << (wide_mode ? 2 : 1));

  logic fetch_done;
  assign fetch_done = busy && (cnt == 2'd3);

  logic            pkt_take, too_big, lp;
  logic [PL_W-1:0] rx_len, padded;
  logic [31:0]     wc_after, addr_after;
  assign pkt_take   = pkt_valid && !busy && !stalled && !reg_we;
  assign rx_len     = PL_W'(pkt_len) + PL_W'(4);
  assign padded     = wide_mode ? (((rx_len - 1'b1) | PL_W'(3)) + 1'b1)
                                : (((rx_len - 1'b1) | PL_W'(1)) + 1'b1);
  assign too_big    = 33'(padded) > {cur_wc, 1'b0};
  assign wc_after   = cur_wc - 32'(padded >> 1);
  assign addr_after = cur_addr + 32'(padded);
  assign lp         = too_big || (wc_after < 32'(thr));

  logic wr_ok;
  logic [1:0] clr;
  logic start_fetch;
  assign wr_ok       = reg_we && !busy;
  assign clr         = (wr_ok && reg_sel == 3'd5) ? (reg_wdata[1:0] & {overrun, exhausted}) : 2'b00;
  assign start_fetch = (wr_ok && reg_sel == 3'd6) || clr[0] ||
                       (pkt_take && lp && rd_ptr != wr_p);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_p   <= '0;
      end_p     <= '0;
      wr_p      <= '0;
      rd_ptr    <= '0;
      thr       <= THR_INIT;
      cnt       <= '0;
      w0        <= '0;
      w1        <= '0;
      w2        <= '0;
      cur_addr  <= '0;
      cur_wc    <= '0;
      busy      <= 1'b0;
      stalled   <= 1'b0;
      exhausted <= 1'b0;
      overrun   <= 1'b0;
      last_pkt  <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (reg_sel)
          3'd0: start_p <= reg_wdata[PTR_W-1:0] & wmask;
          3'd1: end_p   <= reg_wdata[PTR_W-1:0] & wmask;
          3'd2: rd_ptr  <= reg_wdata[PTR_W-1:0] & wmask;
          3'd3: wr_p    <= reg_wdata[PTR_W-1:0] & wmask;
          3'd4: thr     <= reg_wdata;
          default: ;
        endcase
      end
      if (start_fetch) begin
        busy    <= 1'b1;
        cnt     <= 2'd0;
        stalled <= 1'b0;
      end
      if (busy) begin
        cnt <= cnt + 2'd1;
        case (cnt)
          2'd0: w0 <= mem_rdata;
          2'd1: w1 <= mem_rdata;
          2'd2: w2 <= mem_rdata;
          default: begin
            cur_addr <= {w1, w0};
            cur_wc   <= {mem_rdata, w2};
            rd_ptr   <= wrapped;
            busy     <= 1'b0;
          end
        endcase
      end
      exhausted <= (exhausted & ~clr[0]) | (fetch_done && wrapped == wr_p);
      overrun   <= (overrun & ~clr[1]) | (pkt_take && too_big);
      if (pkt_take) begin
        last_pkt <= lp;
        if (!too_big) begin
          cur_addr <= addr_after;
          cur_wc   <= wc_after;
        end
        if (lp && rd_ptr == wr_p) stalled <= 1'b1;
      end
    end
  end

  p_ptr_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr[0] == 1'b0);

  p_busy_four_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(busy, 1) && $past(busy, 2) && $past(busy, 3) &&
                     $past(busy, 4) && !$past(busy, 5)));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_done && next_rd == end_p) |=> (rd_ptr == start_p));

  p_exhaust_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_done && wrapped == wr_p) |=> exhausted);

  p_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_take && too_big) |=> ($stable(cur_addr) && $stable(cur_wc) && overrun && last_pkt));

  p_stall_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !stalled);

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_sel == 3'd4) |=> $stable(thr));
endmodule

// File: tb/rxbuf_ring_bench.sv
`timescale 1ns/1ps
module rxbuf_ring_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] mem_addr;
  logic mem_rd;
  logic [15:0] mem_rdata;
  logic pkt_valid = 1'b0;
  logic [15:0] pkt_len = '0;
  logic [31:0] cur_addr, cur_wc;
  logic [15:0] rd_ptr;
  logic busy, stalled, exhausted, overrun, last_pkt;

  logic [15:0] mem [0:255];
  assign mem_rdata = mem[mem_addr[8:1]];

  always #2 clk = ~clk;

  rxbuf_ring u_rxbuf_ring (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .pkt_valid(pkt_valid), .pkt_len(pkt_len),
    .cur_addr(cur_addr), .cur_wc(cur_wc), .rd_ptr(rd_ptr),
    .busy(busy), .stalled(stalled), .exhausted(exhausted),
    .overrun(overrun), .last_pkt(last_pkt)
  );

  int checks = 0;
  int errors = 0;

  logic [15:0] m_start, m_end, m_rd, m_wr, m_thr;
  logic [31:0] m_addr, m_wc;
  logic m_exh, m_ovr, m_last, m_stall;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check(tag, "cur_addr", cur_addr, m_addr);
    check(tag, "cur_wc", cur_wc, m_wc);
    check(tag, "rd_ptr", 32'(rd_ptr), 32'(m_rd));
    check(tag, "busy", 32'(busy), 32'(0));
    check(tag, "stalled", 32'(stalled), 32'(m_stall));
    check(tag, "exhausted", 32'(exhausted), 32'(m_exh));
    check(tag, "overrun", 32'(overrun), 32'(m_ovr));
    check(tag, "last_pkt", 32'(last_pkt), 32'(m_last));
  endtask

  function automatic logic [15:0] amask(logic [15:0] v);
    return wide ? (v & 16'hFFFC) : (v & 16'hFFFE);
  endfunction

  function automatic int stp();
    return wide ? 4 : 2;
  endfunction

  task automatic put_desc(logic [15:0] p, logic [31:0] a, logic [31:0] wc);
    mem[8'((p + 0 * stp()) >> 1)] = a[15:0];
    mem[8'((p + 1 * stp()) >> 1)] = a[31:16];
    mem[8'((p + 2 * stp()) >> 1)] = wc[15:0];
    mem[8'((p + 3 * stp()) >> 1)] = wc[31:16];
  endtask

  task automatic model_fetch();
    m_addr = {mem[8'((m_rd + 1 * stp()) >> 1)], mem[8'(m_rd >> 1)]};
    m_wc   = {mem[8'((m_rd + 3 * stp()) >> 1)], mem[8'((m_rd + 2 * stp()) >> 1)]};
    m_rd   = m_rd + (wide ? 16'd16 : 16'd8);
    if (m_rd == m_end) m_rd = m_start;
    if (m_rd == m_wr) m_exh = 1'b1;
    m_stall = 1'b0;
  endtask

  task automatic run_fetch(string tag, int seen);
    int n = seen;
    while (busy && n < 10) begin
      n++;
      tick();
    end
    check(tag, "busy cycles", 32'(n), 32'(4));
    model_fetch();
    check_all(tag);
  endtask

  task automatic wreg(logic [2:0] s, logic [15:0] v);
    reg_we = 1'b1;
    reg_sel = s;
    reg_wdata = v;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic set_reg(logic [2:0] s, logic [15:0] v);
    wreg(s, v);
    case (s)
      3'd0: m_start = amask(v);
      3'd1: m_end = amask(v);
      3'd2: m_rd = amask(v);
      3'd3: m_wr = amask(v);
      3'd4: m_thr = v;
      default: ;
    endcase
  endtask

  task automatic cmd_fetch(string tag);
    wreg(3'd6, 16'h0);
    run_fetch(tag, 0);
  endtask

  task automatic clear_flags(string tag, logic [1:0] v);
    logic do_f;
    do_f = v[0] && m_exh;
    wreg(3'd5, {14'h0, v});
    if (v[0]) m_exh = 1'b0;
    if (v[1]) m_ovr = 1'b0;
    if (do_f) run_fetch(tag, 0);
    else check_all(tag);
  endtask

  task automatic send_pkt(string tag, int len);
    logic needf;
    longint pad;
    int rx;
    pkt_valid = 1'b1;
    pkt_len = len[15:0];
    tick();
    pkt_valid = 1'b0;
    needf = 1'b0;
    if (!m_stall) begin
      rx = len + 4;
      pad = wide ? (((rx - 1) | 3) + 1) : (((rx - 1) | 1) + 1);
      m_last = 1'b0;
      if (pad > 2 * longint'(m_wc)) begin
        m_ovr = 1'b1;
        m_last = 1'b1;
      end else begin
        m_addr = m_addr + 32'(pad);
        m_wc = m_wc - 32'(pad / 2);
        if (m_wc < {16'h0, m_thr}) m_last = 1'b1;
      end
      if (m_last) begin
        if (m_rd == m_wr) m_stall = 1'b1;
        else needf = 1'b1;
      end
    end
    if (needf) run_fetch(tag, 0);
    else check_all(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    m_start = 0; m_end = 0; m_rd = 0; m_wr = 0; m_thr = 16'h02F8;
    m_addr = 0; m_wc = 0; m_exh = 0; m_ovr = 0; m_last = 0; m_stall = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2 narrow masking, ring 0x40..0x60
    set_reg(3'd0, 16'h0040);
    set_reg(3'd1, 16'h0061);
    set_reg(3'd3, 16'h0059);
    set_reg(3'd2, 16'h0041);
    check("R2", "rd_ptr narrow mask", 32'(rd_ptr), 32'h40);

    put_desc(16'h40, 32'h0001_2000, 32'h300);
    put_desc(16'h48, 32'h0000_3000, 32'h1000);
    put_desc(16'h50, 32'h0005_0000, 32'h40);
    put_desc(16'h58, 32'h0006_0000, 32'h20);
    cmd_fetch("R3");
    // R1 default threshold 0x2F8: 0x300 - 32 = 0x2E0 below it, so R8 fetch
    send_pkt("R8", 60);
    check("R1", "last_pkt from reset threshold", 32'(last_pkt), 32'(1));
    set_reg(3'd4, 16'h0010);
    send_pkt("R6", 1);
    send_pkt("R6", 3);
    send_pkt("R6", 6);
    // R7 oversize refused, last -> fetch slot 0x50, rd lands on wr: R5
    send_pkt("R7", 10000);
    check("R5", "exhausted", 32'(exhausted), 32'(1));
    check("R7", "overrun", 32'(overrun), 32'(1));
    // R10 clear overrun only, no fetch
    clear_flags("R10", 2'b10);
    // R10 clear exhausted -> fetch slot 0x58, R4 wrap to 0x40
    clear_flags("R10", 2'b01);
    check("R4", "rd_ptr wrapped", 32'(rd_ptr), 32'h40);
    // exact fit: 0x20 words = 64 bytes, len 60 accepted
    set_reg(3'd3, 16'h0040);
    send_pkt("R8", 60);
    check("R9", "stalled", 32'(stalled), 32'(1));
    send_pkt("R9", 10);
    cmd_fetch("R9");
    // R11: writes and frames during a fetch are ignored
    wreg(3'd6, 16'h0);
    reg_we = 1'b1; reg_sel = 3'd2; reg_wdata = 16'h0100;
    pkt_valid = 1'b1; pkt_len = 16'd4;
    tick();
    reg_we = 1'b0; pkt_valid = 1'b0;
    reg_we = 1'b1; reg_sel = 3'd4; reg_wdata = 16'h7777;
    tick();
    reg_we = 1'b0;
    run_fetch("R11", 2);
    send_pkt("R11", 2);

    // wide mode ring 0x80..0xB0
    wide = 1'b1;
    set_reg(3'd0, 16'h0082);
    set_reg(3'd1, 16'h00B3);
    set_reg(3'd3, 16'h00A3);
    set_reg(3'd2, 16'h0083);
    check("R2", "rd_ptr wide mask", 32'(rd_ptr), 32'h80);
    put_desc(16'h80, 32'h0010_0000, 32'h800);
    put_desc(16'h90, 32'h0020_0000, 32'h30);
    put_desc(16'hA0, 32'h0030_0000, 32'h900);
    cmd_fetch("R3");
    send_pkt("R6", 1);
    send_pkt("R6", 61);
    send_pkt("R6", 62);
    cmd_fetch("R5");
    cmd_fetch("R4");

    // random phase
    for (int ph = 0; ph < 4; ph++) begin
      wide = ph[0];
      set_reg(3'd0, 16'h0100);
      set_reg(3'd1, 16'h0140);
      set_reg(3'd2, 16'h0100);
      set_reg(3'd3, 16'h0100 + 16'($urandom_range(0, 3)) * 16'h10);
      for (int k = 0; k < (wide ? 4 : 8); k++)
        put_desc(16'h0100 + 16'(k * (wide ? 16 : 8)), $urandom(), 32'($urandom_range(0, 2500)));
      for (int it = 0; it < 40; it++) begin
        int r = $urandom_range(0, 9);
        if (m_stall) cmd_fetch("R9");
        else if (r < 6) send_pkt("R6", $urandom_range(1, 1600));
        else if (r == 6) begin
          set_reg(3'd4, 16'($urandom_range(0, 1200)));
          check_all("R8");
        end else if (r == 7) clear_flags("R10", 2'($urandom_range(0, 3)));
        else cmd_fetch("R3");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule